// File: doc/BRIEF.md
# Always-On Wakeup Source Controller

This block lives in the always-on power domain and decides when the chip leaves a low-power state. It watches a requested power mode (run, deep-sleep or power-off) and five raw wakeup requests: a GPIO request, an RTC request and three baseband candidates (oscillator enable, radio enable and low-power wakeup). Each request first passes through a flop synchronizer into the always-on clock. Control inputs then gate the synchronized requests: a per-source enable for GPIO and RTC, a two-bit baseband source select and an automatic low-speed-oscillator shutdown option. Which sources are legal depends on the current sleep mode.

A small state machine tracks the power state. Its states are RUN (awake), DEEP (deep-sleep armed), OFF (power-off armed), WAKE (a one-cycle wakeup pulse) and WAIT (woken, waiting for software to return the mode to run). The transitions are:
- RUN goes to DEEP or OFF when the mode input asks for it.
- DEEP and OFF go to WAKE on any legal hit. Without a hit they follow the mode input: to the other sleep state, or back to RUN.
- WAKE goes to WAIT while the mode still requests sleep, and to RUN otherwise.
- WAIT goes to RUN once the mode returns to run.

Each wake event sets sticky per-source status bits, which software clears. The OR of the status bits forms an interrupt. A wake from power-off also sets a power-off log flag. Two hold stages either pass the baseband and GPIO control signals from the core through, or freeze their last values.

Top module: `aon_wake_ctrl`

## Requirements
- R1: Mode input codes are 2'b00 run, 2'b01 deep-sleep, 2'b10 power-off and 2'b11 treated as run. In deep-sleep with auto-off clear, baseband select code 2'b00 disables baseband wakeup. Code 2'b01 wakes on oscillator enable, 2'b10 on radio enable and 2'b11 on the low-power wakeup signal. A baseband signal that is not selected has no effect.
- R2: In power-off, only select code 2'b01 (oscillator enable) can wake the chip. Codes 2'b10 and 2'b11 behave as disabled.
- R3: GPIO and RTC requests wake the chip only when their own enable is 1. This holds in both deep-sleep and power-off.
- R4: With auto-off set, RTC and all baseband requests are ignored in both sleep modes. Only an enabled GPIO request wakes the chip.
- R5: The low-speed oscillator enable output is 1 after reset and in run. It is 0 while the block sleeps with auto-off set, and returns to 1 from the cycle of the wake pulse.
- R6: The wake pulse is exactly one cycle wide. It appears in the third clock cycle after a legal request is raised (two synchronizer stages plus the state register). It is never produced while the mode has been run. A held request gives no second pulse until the mode has returned to run.
- R7: Status bits (bit0 GPIO, bit1 baseband, bit2 RTC) are set in the cycle of the wake pulse for each legal active source. They stay set until the matching bit of the clear input is 1.
- R8: The interrupt output equals the OR of the three status bits.
- R9: With its active-low hold control at 1, each hold stage passes its core input through in the same cycle. At 0, it keeps the value its input had at the last clock edge at which the control was 1.
- R10: The power-off log is 0 after reset and is set by a wake from power-off but not by a wake from deep-sleep. It stays set in run until the clear input is 1.
- R11: After reset the status is 0, the interrupt is 0, the wake pulse is 0 and the state is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low power-on reset |
| mode_i | input | 2 | Requested power mode |
| gpio_wake_en_i | input | 1 | GPIO wakeup enable |
| rtc_wake_en_i | input | 1 | RTC wakeup enable |
| bb_wake_sel_i | input | 2 | Baseband wakeup source select |
| auto_osc_off_i | input | 1 | Automatic low-speed oscillator shutdown |
| gpio_req_i | input | 1 | Raw GPIO wakeup request |
| rtc_req_i | input | 1 | Raw RTC wakeup request |
| bb_osc_en_i | input | 1 | Baseband oscillator-enable candidate |
| bb_radio_en_i | input | 1 | Baseband radio-enable candidate |
| bb_lp_wake_i | input | 1 | Baseband low-power wakeup candidate |
| stat_clr_i | input | 3 | Per-bit status clear |
| poff_log_clr_i | input | 1 | Power-off log clear |
| bb_latch_n_i | input | 1 | Baseband hold control, 1 = pass |
| io_latch_n_i | input | 1 | GPIO hold control, 1 = pass |
| bb_core_i | input | BB_W | Baseband signals from core |
| io_core_i | input | IO_W | GPIO controls from core |
| wake_pulse_o | output | 1 | One-cycle wakeup pulse |
| wake_stat_o | output | 3 | Sticky wakeup status |
| pmu_irq_o | output | 1 | Interrupt, OR of status |
| poff_log_o | output | 1 | Woken-from-power-off flag |
| lposc_en_o | output | 1 | Low-speed oscillator enable |
| bb_hold_o | output | BB_W | Held baseband signals |
| io_hold_o | output | IO_W | Held GPIO controls |

## Verification
The assertions check the following on every cycle: the pulse is one cycle wide, there is no pulse after two cycles of run mode, status bits stay set until cleared, a new status bit only ever appears together with a pulse, the log rises only with a pulse, and a frozen hold stage is stable. Only the bench scenarios can show that each select code and source enable is legal or illegal in the right sleep mode and under auto-off, that the pulse latency is exact, and that the hold stages capture the right value.

// File: rtl/aon_wake_pkg.sv
package aon_wake_pkg;

    localparam int NUM_SRC  = 3;
    localparam int SRC_GPIO = 0;
    localparam int SRC_BB   = 1;
    localparam int SRC_RTC  = 2;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_DEEP = 2'b01,
        MODE_OFF  = 2'b10,
        MODE_RSVD = 2'b11
    } pwr_mode_e;

    typedef enum logic [1:0] {
        BBSEL_NONE  = 2'b00,
        BBSEL_OSC   = 2'b01,
        BBSEL_RADIO = 2'b10,
        BBSEL_LP    = 2'b11
    } bb_sel_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_DEEP,
        ST_OFF,
        ST_WAKE,
        ST_WAIT
    } wk_state_e;

endpackage

// File: rtl/aon_sync.sv
module aon_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/aon_src_gate.sv
module aon_src_gate
    import aon_wake_pkg::*;
(
    input  logic               in_deep_i,
    input  logic               in_off_i,
    input  logic               gpio_en_i,
    input  logic               rtc_en_i,
    input  logic [1:0]         sel_i,
    input  logic               auto_i,
    input  logic               gpio_i,
    input  logic               rtc_i,
    input  logic               osc_i,
    input  logic               radio_i,
    input  logic               lp_i,
    output logic [NUM_SRC-1:0] hit_o
);
    logic asleep;
    logic bb_cand;
    logic bb_mode_ok;

    assign asleep = in_deep_i | in_off_i;

    // Baseband candidate and its legality in the current sleep mode
    always_comb begin
        bb_cand    = 1'b0;
        bb_mode_ok = 1'b0;
        unique case (sel_i)
            BBSEL_NONE: begin
                bb_cand    = 1'b0;
                bb_mode_ok = 1'b0;
            end
            BBSEL_OSC: begin
                bb_cand    = osc_i;
                bb_mode_ok = asleep;
            end
            BBSEL_RADIO: begin
                bb_cand    = radio_i;
                bb_mode_ok = in_deep_i;
            end
            BBSEL_LP: begin
                bb_cand    = lp_i;
                bb_mode_ok = in_deep_i;
            end
        endcase
    end

    always_comb begin
        hit_o           = '0;
        hit_o[SRC_GPIO] = asleep & gpio_en_i & gpio_i;
        hit_o[SRC_RTC]  = asleep & rtc_en_i & rtc_i & ~auto_i;
        hit_o[SRC_BB]   = bb_mode_ok & bb_cand & ~auto_i;
    end
endmodule

// File: rtl/aon_wake_fsm.sv
module aon_wake_fsm
    import aon_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       any_hit_i,
    input  logic       auto_i,
    output logic       in_deep_o,
    output logic       in_off_o,
    output logic       wake_pulse_o,
    output logic       lposc_en_o
);
    wk_state_e state_q;
    wk_state_e state_d;
    logic      want_deep;
    logic      want_off;

    assign want_deep = (mode_i == MODE_DEEP);
    assign want_off  = (mode_i == MODE_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (want_deep)     state_d = ST_DEEP;
                else if (want_off) state_d = ST_OFF;
            end
            ST_DEEP: begin
                if (any_hit_i)     state_d = ST_WAKE;
                else if (want_off) state_d = ST_OFF;
                else if (!want_deep) state_d = ST_RUN;
            end
            ST_OFF: begin
                if (any_hit_i)      state_d = ST_WAKE;
                else if (want_deep) state_d = ST_DEEP;
                else if (!want_off) state_d = ST_RUN;
            end
            ST_WAKE: begin
                if (want_deep || want_off) state_d = ST_WAIT;
                else                       state_d = ST_RUN;
            end
            ST_WAIT: begin
                if (!want_deep && !want_off) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        in_deep_o    = (state_q == ST_DEEP);
        in_off_o     = (state_q == ST_OFF);
        wake_pulse_o = (state_q == ST_WAKE);
        lposc_en_o   = ~(auto_i & ((state_q == ST_DEEP) | (state_q == ST_OFF)));
    end

    // R6: the pulse never lasts beyond one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |=> !wake_pulse_o);
endmodule

// File: rtl/aon_sticky_stat.sv
module aon_sticky_stat #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            poff_set_i,
    input  logic            poff_clr_i,
    output logic [NSRC-1:0] stat_o,
    output logic            poff_log_o
);
    logic [NSRC-1:0] stat_q;
    logic            poff_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          stat_q[i] <= 1'b0;
            else if (set_i[i])   stat_q[i] <= 1'b1;
            else if (clr_i[i])   stat_q[i] <= 1'b0;
        end

        // R7: a set bit survives every cycle without its clear
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          poff_q <= 1'b0;
        else if (poff_set_i) poff_q <= 1'b1;
        else if (poff_clr_i) poff_q <= 1'b0;
    end

    assign stat_o     = stat_q;
    assign poff_log_o = poff_q;
endmodule

// File: rtl/aon_hold_latch.sv
module aon_hold_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pass_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_q <= '0;
        else if (pass_i) held_q <= d_i;
    end

    assign q_o = pass_i ? d_i : held_q;

    // R9: a frozen stage keeps its output stable
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_i && $past(!pass_i)) |-> $stable(q_o));
endmodule

// File: rtl/aon_wake_ctrl.sv
module aon_wake_ctrl
    import aon_wake_pkg::*;
#(
    parameter int BB_W        = 4,
    parameter int IO_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic               gpio_wake_en_i,
    input  logic               rtc_wake_en_i,
    input  logic [1:0]         bb_wake_sel_i,
    input  logic               auto_osc_off_i,
    input  logic               gpio_req_i,
    input  logic               rtc_req_i,
    input  logic               bb_osc_en_i,
    input  logic               bb_radio_en_i,
    input  logic               bb_lp_wake_i,
    input  logic [2:0]         stat_clr_i,
    input  logic               poff_log_clr_i,
    input  logic               bb_latch_n_i,
    input  logic               io_latch_n_i,
    input  logic [BB_W-1:0]    bb_core_i,
    input  logic [IO_W-1:0]    io_core_i,
    output logic               wake_pulse_o,
    output logic [2:0]         wake_stat_o,
    output logic               pmu_irq_o,
    output logic               poff_log_o,
    output logic               lposc_en_o,
    output logic [BB_W-1:0]    bb_hold_o,
    output logic [IO_W-1:0]    io_hold_o
);
    localparam int NREQ = 5;

    logic [NREQ-1:0]    req_raw;
    logic [NREQ-1:0]    req_sync;
    logic [NUM_SRC-1:0] hit;
    logic               any_hit;
    logic               in_deep;
    logic               in_off;

    assign req_raw = {bb_lp_wake_i, bb_radio_en_i, bb_osc_en_i, rtc_req_i, gpio_req_i};

    aon_sync #(.W(NREQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_raw),
        .q_o   (req_sync)
    );

    aon_src_gate u_gate (
        .in_deep_i (in_deep),
        .in_off_i  (in_off),
        .gpio_en_i (gpio_wake_en_i),
        .rtc_en_i  (rtc_wake_en_i),
        .sel_i     (bb_wake_sel_i),
        .auto_i    (auto_osc_off_i),
        .gpio_i    (req_sync[0]),
        .rtc_i     (req_sync[1]),
        .osc_i     (req_sync[2]),
        .radio_i   (req_sync[3]),
        .lp_i      (req_sync[4]),
        .hit_o     (hit)
    );

    assign any_hit = |hit;

    aon_wake_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .any_hit_i    (any_hit),
        .auto_i       (auto_osc_off_i),
        .in_deep_o    (in_deep),
        .in_off_o     (in_off),
        .wake_pulse_o (wake_pulse_o),
        .lposc_en_o   (lposc_en_o)
    );

    aon_sticky_stat #(.NSRC(NUM_SRC)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (hit),
        .clr_i      (stat_clr_i),
        .poff_set_i (in_off & any_hit),
        .poff_clr_i (poff_log_clr_i),
        .stat_o     (wake_stat_o),
        .poff_log_o (poff_log_o)
    );

    assign pmu_irq_o = |wake_stat_o;

    aon_hold_latch #(.W(BB_W)) u_bb_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .pass_i (bb_latch_n_i),
        .d_i    (bb_core_i),
        .q_o    (bb_hold_o)
    );

    aon_hold_latch #(.W(IO_W)) u_io_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .pass_i (io_latch_n_i),
        .d_i    (io_core_i),
        .q_o    (io_hold_o)
    );

    // R6: two cycles of run mode leave no room for a pulse
    a_r6_no_pulse_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == MODE_RUN && $past(mode_i, 2) == MODE_RUN) |-> !wake_pulse_o);

    // R7: a status bit only appears together with a wake pulse
    a_r7_set_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wake_stat_o & ~$past(wake_stat_o))) |-> wake_pulse_o);

    // R10: the log only rises together with a wake pulse
    a_r10_log_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(poff_log_o) |-> wake_pulse_o);
endmodule

// File: tb/test_aon_wake_ctrl.sv
module test_aon_wake_ctrl;
    localparam int BB_W = 4;
    localparam int IO_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode_i = 2'b00;
    logic            gpio_wake_en_i = 1'b0, rtc_wake_en_i = 1'b0;
    logic [1:0]      bb_wake_sel_i = 2'b00;
    logic            auto_osc_off_i = 1'b0;
    logic            gpio_req_i = 1'b0, rtc_req_i = 1'b0;
    logic            bb_osc_en_i = 1'b0, bb_radio_en_i = 1'b0, bb_lp_wake_i = 1'b0;
    logic [2:0]      stat_clr_i = 3'b000;
    logic            poff_log_clr_i = 1'b0;
    logic            bb_latch_n_i = 1'b1, io_latch_n_i = 1'b1;
    logic [BB_W-1:0] bb_core_i = '0;
    logic [IO_W-1:0] io_core_i = '0;
    logic            wake_pulse_o;
    logic [2:0]      wake_stat_o;
    logic            pmu_irq_o, poff_log_o, lposc_en_o;
    logic [BB_W-1:0] bb_hold_o;
    logic [IO_W-1:0] io_hold_o;

    int vectors = 0;
    int miscompares = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        string    tag;
        int       pulses;
        logic [2:0] stat;
        logic     poff;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #2 clk = ~clk;

    aon_wake_ctrl #(.BB_W(BB_W), .IO_W(IO_W)) i_aon_wake_ctrl (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Expected status from the requirements (R1-style codes written out below)
    function automatic logic [2:0] model(input logic [1:0] m, input logic [1:0] sel,
        input logic au, input logic ge, input logic re, input logic g, input logic r,
        input logic o, input logic ra, input logic lp);
        logic [2:0] s;
        logic deep, off;
        deep = (m == 2'b01);
        off  = (m == 2'b10);
        s = 3'b000;
        if (deep || off) begin
            s[0] = ge & g;
            s[2] = re & r & ~au;
            s[1] = ~au & ((sel == 2'b01 && o) || (deep && sel == 2'b10 && ra) ||
                          (deep && sel == 2'b11 && lp));
        end
        return s;
    endfunction

    // Monitor: pops expected items and compares with observed results
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wake_pulse_o) pulse_cnt++;
            if (exp_q.size() > 0) begin
                exp_item_t e;
                e = exp_q.pop_front();
                check(pulse_cnt == e.pulses, {e.tag, " R6 pulse count"}, pulse_cnt, e.pulses);
                check(wake_stat_o == e.stat, {e.tag, " R7 status"}, wake_stat_o, e.stat);
                check(pmu_irq_o == |e.stat, {e.tag, " R8 irq"}, pmu_irq_o, |e.stat);
                check(poff_log_o == e.poff, {e.tag, " R10 log"}, poff_log_o, e.poff);
                pulse_cnt = 0;
            end
        end
    end

    task automatic trial(input logic [1:0] m, input logic [1:0] sel, input logic au,
        input logic ge, input logic re, input logic g, input logic r, input logic o,
        input logic ra, input logic lp, input string tag);
        exp_item_t e;
        logic [2:0] s;
        logic sleep;
        s = model(m, sel, au, ge, re, g, r, o, ra, lp);
        sleep = (m == 2'b01) || (m == 2'b10);
        mode_i = 2'b00;
        bb_wake_sel_i = sel; auto_osc_off_i = au;
        gpio_wake_en_i = ge; rtc_wake_en_i = re;
        stat_clr_i = 3'b111; poff_log_clr_i = 1'b1;
        step(1);
        stat_clr_i = 3'b000; poff_log_clr_i = 1'b0;
        mode_i = m;
        step(3);
        check(lposc_en_o == !(sleep && au), {tag, " R5 osc asleep"}, lposc_en_o, !(sleep && au));
        gpio_req_i = g; rtc_req_i = r;
        bb_osc_en_i = o; bb_radio_en_i = ra; bb_lp_wake_i = lp;
        step(6);
        check(lposc_en_o == !(sleep && au && s == 3'b000), {tag, " R5 osc after"},
              lposc_en_o, !(sleep && au && s == 3'b000));
        e.tag = tag; e.pulses = (s != 3'b000) ? 1 : 0;
        e.stat = s; e.poff = (m == 2'b10) && (s != 3'b000);
        exp_q.push_back(e);
        step(2);
        gpio_req_i = 0; rtc_req_i = 0; bb_osc_en_i = 0; bb_radio_en_i = 0; bb_lp_wake_i = 0;
        mode_i = 2'b00;
        step(3);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        exp_item_t e;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R11 reset state
        check(wake_stat_o == 3'b000, "R11 status", wake_stat_o, 0);
        check(pmu_irq_o == 1'b0, "R11 irq", pmu_irq_o, 0);
        check(wake_pulse_o == 1'b0, "R11 pulse", wake_pulse_o, 0);
        check(poff_log_o == 1'b0, "R10 log after reset", poff_log_o, 0);
        check(lposc_en_o == 1'b1, "R5 osc after reset", lposc_en_o, 1);

        // R1, R2: every select code against every baseband signal in both modes
        for (int md = 1; md <= 2; md++) begin
            for (int sl = 0; sl < 4; sl++) begin
                for (int k = 0; k < 3; k++) begin
                    trial(md[1:0], sl[1:0], 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                          k == 0, k == 1, k == 2,
                          $sformatf("R1/R2 mode%0d sel%0d sig%0d", md, sl, k));
                end
            end
        end

        // R3: GPIO and RTC enables in both sleep modes
        for (int md = 1; md <= 2; md++) begin
            trial(md[1:0], 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 0, "R3 gpio enabled");
            trial(md[1:0], 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 0, "R3 gpio disabled");
            trial(md[1:0], 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0, 0, 0, "R3 rtc enabled");
            trial(md[1:0], 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 0, "R3 rtc disabled");
        end

        // R4: auto-off leaves only GPIO
        for (int md = 1; md <= 2; md++) begin
            trial(md[1:0], 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 0, 0, "R4 auto rtc");
            trial(md[1:0], 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1, "R4 auto bb lp");
            trial(md[1:0], 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1, 0, 0, "R4 auto bb osc");
            trial(md[1:0], 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1, 0, 0, "R4 auto gpio");
        end

        // R6: no pulse in run mode, even with every source active
        trial(2'b00, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1, 1, "R6 run mode");
        trial(2'b11, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1, 1, "R6 reserved mode");

        // R7, R8: multiple sources, then per-bit clear
        trial(2'b01, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 0, 0, "R7 gpio+rtc");
        stat_clr_i = 3'b001;
        step(1);
        stat_clr_i = 3'b000;
        check(wake_stat_o == 3'b100, "R7 partial clear", wake_stat_o, 3'b100);
        check(pmu_irq_o == 1'b1, "R8 irq one bit", pmu_irq_o, 1);
        stat_clr_i = 3'b100;
        step(1);
        stat_clr_i = 3'b000;
        check(wake_stat_o == 3'b000, "R7 full clear", wake_stat_o, 0);
        check(pmu_irq_o == 1'b0, "R8 irq none", pmu_irq_o, 0);

        // R10: log stays in run until cleared
        trial(2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 0, 0, 1, 0, 0, "R10 poff osc wake");
        step(2);
        check(poff_log_o == 1'b1, "R10 log held in run", poff_log_o, 1);
        poff_log_clr_i = 1'b1;
        step(1);
        poff_log_clr_i = 1'b0;
        check(poff_log_o == 1'b0, "R10 log cleared", poff_log_o, 0);

        // R6: exact latency and width of the pulse
        stat_clr_i = 3'b111;
        gpio_wake_en_i = 1'b1; auto_osc_off_i = 1'b0;
        step(1);
        stat_clr_i = 3'b000;
        mode_i = 2'b01;
        step(3);
        gpio_req_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(wake_pulse_o == 1'b0, "R6 not early", wake_pulse_o, 0);
        @(negedge clk);
        check(wake_pulse_o == 1'b1, "R6 pulse in third cycle", wake_pulse_o, 1);
        @(negedge clk);
        check(wake_pulse_o == 1'b0, "R6 one cycle wide", wake_pulse_o, 0);
        step(4);
        e.tag = "R6 latency held req"; e.pulses = 1; e.stat = 3'b001; e.poff = 1'b0;
        exp_q.push_back(e);
        step(2);
        gpio_req_i = 1'b0; mode_i = 2'b00;
        step(3);

        // R9: hold stages pass through and freeze
        bb_latch_n_i = 1'b1; io_latch_n_i = 1'b1;
        bb_core_i = 4'hA; io_core_i = 8'h3C;
        #1;
        check(bb_hold_o == 4'hA, "R9 bb pass", bb_hold_o, 4'hA);
        check(io_hold_o == 8'h3C, "R9 io pass", io_hold_o, 8'h3C);
        step(1);
        bb_latch_n_i = 1'b0; io_latch_n_i = 1'b0;
        bb_core_i = 4'h5; io_core_i = 8'hC1;
        #1;
        check(bb_hold_o == 4'hA, "R9 bb frozen", bb_hold_o, 4'hA);
        check(io_hold_o == 8'h3C, "R9 io frozen", io_hold_o, 8'h3C);
        step(3);
        bb_core_i = 4'h9; io_core_i = 8'h77;
        step(1);
        check(bb_hold_o == 4'hA, "R9 bb still frozen", bb_hold_o, 4'hA);
        check(io_hold_o == 8'h3C, "R9 io still frozen", io_hold_o, 8'h3C);
        bb_latch_n_i = 1'b1;
        #1;
        check(bb_hold_o == 4'h9, "R9 bb released", bb_hold_o, 4'h9);
        check(io_hold_o == 8'h3C, "R9 io independent", io_hold_o, 8'h3C);
        step(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule